// File: doc/BRIEF.md
# Debounced Port-Change Interrupt Unit

This block watches an 8-bit input port and turns its activity into two interrupt requests. A port-change request is raised whenever any bit of the port changes value. An external request is raised by a chosen edge on pin 0: rising or falling, set by software. Both requests come from one filtered copy of the port. That copy is either the port after a two-flop synchroniser or, when the debounce filter is on, the last value that stayed steady for a programmed number of slow sampling ticks.

Software sees three byte-wide registers on a small register bus: a control register, a request-flag register and an enable register. Each request flag is set by hardware and stays set until software writes a 1 to its bit. A flag reaches its interrupt output only while its enable bit is set. The slow sampling clock arrives as `sample_tick`, a one-cycle strobe in the system clock domain, once per slow period. All pins are plain level or strobe control. There is no streaming path, so no valid/ready handshake applies.

Top module: `port_irq_unit`

## Requirements
- R1: After reset the control register (address 0xF) reads 0x80. The flag register (0xD) and the enable register (0xE) read 0. `pullup_en` is 1, and both interrupt outputs are 0.
- R2: In the control register, bit 7 drives `pullup_en`, bit 6 turns on debounce and bit 5 selects the edge for pin 0. Bits 4 to 0 read as 0 whatever was written to them. Addresses other than 0xD, 0xE and 0xF read 0.
- R3: With debounce off, a change on any port bit sets flag bit 1 (port change). The flag can first be read after the third rising clock edge that follows the input change.
- R4: Edge select 1 makes a rising edge on pin 0 set flag bit 0 (external). Edge select 0 makes a falling edge set it. The opposite edge leaves flag bit 0 unchanged.
- R5: While `pin0_is_input` is 0, edges on pin 0 never set flag bit 0.
- R6: With debounce on, a new port value is accepted only on the sample tick on which it has been seen on DB_TICKS consecutive ticks. Requests are raised only from accepted values.
- R7: With debounce on, a change to a different value during the window restarts the count. A value that returns to the accepted one before acceptance raises no request.
- R8: One qualifying edge on pin 0 sets both flag bit 0 and flag bit 1 in the same cycle.
- R9: Flags are sticky. Writing 1 to a bit of the flag register clears it, and writing 0 has no effect. A hardware set in the same cycle as a clear leaves the flag set.
- R10: `irq_ext` is flag bit 0 AND enable bit 0. `irq_port` is flag bit 1 AND enable bit 1. Flags still set while their enable bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_in | input | 8 | Raw port pins |
| pin0_is_input | input | 1 | Pin 0 is configured as an input |
| sample_tick | input | 1 | One-cycle strobe per slow sampling period |
| bus_addr | input | 4 | Register address |
| bus_wr | input | 1 | Register write strobe |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| pullup_en | output | 1 | Pull-up enable to the pads |
| irq_ext | output | 1 | External pin-0 interrupt request |
| irq_port | output | 1 | Port-change interrupt request |

## Verification
The port is driven with single-bit changes on upper bits, with rising and falling edges on pin 0 under both edge selections, and with pin 0 edges while the pin is not an input. Together these separate the port-change path from the external path and show the edge polarity. With debounce on, the patterns are a change held through the window, a glitch that returns before acceptance, and a second bit changing during the window. These tell a restarting counter from one that keeps counting or accepts early. One flag clear is timed to land on the same edge as a hardware set, to prove that the set has priority.

// File: rtl/port_irq_pkg.sv
package port_irq_pkg;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 8;

  localparam logic [ADDR_W-1:0] FLAG_ADDR = 4'hD;
  localparam logic [ADDR_W-1:0] ENAB_ADDR = 4'hE;
  localparam logic [ADDR_W-1:0] CTRL_ADDR = 4'hF;

  // control register bit positions
  localparam int CTRL_PULL_BIT = 7;
  localparam int CTRL_DBN_BIT  = 6;
  localparam int CTRL_RISE_BIT = 5;

  // flag / enable bit positions
  localparam int EXT_BIT  = 0;
  localparam int PORT_BIT = 1;

  typedef struct packed {
    logic pull;
    logic dbn;
    logic rise;
  } ctrl_t;

  localparam ctrl_t CTRL_RESET = '{pull: 1'b1, dbn: 1'b0, rise: 1'b0};
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= '0;
    else        chain[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[s] <= '0;
      else        chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/debounce_filter.sv
module debounce_filter #(
  parameter int W        = 8,
  parameter int DB_TICKS = 512
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         enable,
  input  logic         tick,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  localparam int CNT_W = (DB_TICKS > 2) ? $clog2(DB_TICKS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DB_TICKS - 1);

  logic [W-1:0]     accepted;
  logic [W-1:0]     cand;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      accepted <= '0;
      cand     <= '0;
      cnt      <= '0;
    end else if (!enable) begin
      // bypass: track input so a later enable starts clean
      accepted <= din;
      cand     <= din;
      cnt      <= '0;
    end else if (tick) begin
      if (din == accepted) begin
        cand <= accepted;
        cnt  <= '0;
      end else if (din != cand) begin
        cand <= din;
        cnt  <= CNT_W'(1);
      end else if (cnt == LAST) begin
        accepted <= din;
        cnt      <= '0;
      end else begin
        cnt <= cnt + CNT_W'(1);
      end
    end
  end

  assign dout = enable ? accepted : din;

  // R6: accepted value only moves on a sample tick while filtering
  a_r6_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !tick) |=> (accepted == $past(accepted)));

  // R7: a sample differing from the candidate never gets accepted on that tick
  a_r7_no_accept_on_new: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && tick && din != cand) |=> $stable(accepted));
endmodule

// File: rtl/edge_events.sv
module edge_events #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] filt,
  input  logic         pin0_in,
  input  logic         rise_sel,
  output logic         ext_ev,
  output logic         chg_ev
);
  logic [W-1:0] prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= '0;
    else        prev <= filt;
  end

  logic went_up, went_down;
  assign went_up   =  filt[0] & ~prev[0];
  assign went_down = ~filt[0] &  prev[0];

  assign chg_ev = (filt != prev);
  assign ext_ev = pin0_in & (rise_sel ? went_up : went_down);

  // R8: every pin-0 event is also a port change
  a_r8_ext_implies_change: assert property (@(posedge clk) disable iff (!rst_n)
    ext_ev |-> chg_ev);
endmodule

// File: rtl/irq_regs.sv
module irq_regs
  import port_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              ext_ev,
  input  logic              chg_ev,
  output ctrl_t             ctrl,
  output logic              irq_ext,
  output logic              irq_port
);
  logic flag_ext, flag_port, en_ext, en_port;
  logic clr_ext, clr_port;
  logic unused_wbits;

  assign unused_wbits = ^bus_wdata[4:2];
  assign clr_ext  = bus_wr && (bus_addr == FLAG_ADDR) && bus_wdata[EXT_BIT];
  assign clr_port = bus_wr && (bus_addr == FLAG_ADDR) && bus_wdata[PORT_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= CTRL_RESET;
    end else if (bus_wr && bus_addr == CTRL_ADDR) begin
      ctrl.pull <= bus_wdata[CTRL_PULL_BIT];
      ctrl.dbn  <= bus_wdata[CTRL_DBN_BIT];
      ctrl.rise <= bus_wdata[CTRL_RISE_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_ext  <= 1'b0;
      en_port <= 1'b0;
    end else if (bus_wr && bus_addr == ENAB_ADDR) begin
      en_ext  <= bus_wdata[EXT_BIT];
      en_port <= bus_wdata[PORT_BIT];
    end
  end

  // hardware set has priority over a software clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_ext  <= 1'b0;
      flag_port <= 1'b0;
    end else begin
      flag_ext  <= ext_ev | (flag_ext  & ~clr_ext);
      flag_port <= chg_ev | (flag_port & ~clr_port);
    end
  end

  assign irq_ext  = flag_ext  & en_ext;
  assign irq_port = flag_port & en_port;

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      CTRL_ADDR: begin
        bus_rdata[CTRL_PULL_BIT] = ctrl.pull;
        bus_rdata[CTRL_DBN_BIT]  = ctrl.dbn;
        bus_rdata[CTRL_RISE_BIT] = ctrl.rise;
      end
      FLAG_ADDR: begin
        bus_rdata[EXT_BIT]  = flag_ext;
        bus_rdata[PORT_BIT] = flag_port;
      end
      ENAB_ADDR: begin
        bus_rdata[EXT_BIT]  = en_ext;
        bus_rdata[PORT_BIT] = en_port;
      end
      default: bus_rdata = '0;
    endcase
  end

  // R9: flags hold unless cleared
  a_r9_ext_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_ext && !clr_ext) |=> flag_ext);
  a_r9_port_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_port && !clr_port) |=> flag_port);
  // R9: a set event wins over a same-cycle clear
  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    chg_ev |=> flag_port);
endmodule

// File: rtl/port_irq_unit.sv
module port_irq_unit
  import port_irq_pkg::*;
#(
  parameter int PORT_W   = 8,
  parameter int DB_TICKS = 512
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PORT_W-1:0] port_in,
  input  logic              pin0_is_input,
  input  logic              sample_tick,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              pullup_en,
  output logic              irq_ext,
  output logic              irq_port
);
  logic [PORT_W-1:0] synced, filtered;
  logic              ext_ev, chg_ev;
  ctrl_t             ctrl;

  pin_sync #(.W(PORT_W), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(port_in), .q(synced)
  );

  debounce_filter #(.W(PORT_W), .DB_TICKS(DB_TICKS)) u_filt (
    .clk(clk), .rst_n(rst_n), .enable(ctrl.dbn), .tick(sample_tick),
    .din(synced), .dout(filtered)
  );

  edge_events #(.W(PORT_W)) u_edges (
    .clk(clk), .rst_n(rst_n), .filt(filtered), .pin0_in(pin0_is_input),
    .rise_sel(ctrl.rise), .ext_ev(ext_ev), .chg_ev(chg_ev)
  );

  irq_regs u_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_ev(ext_ev),
    .chg_ev(chg_ev), .ctrl(ctrl), .irq_ext(irq_ext), .irq_port(irq_port)
  );

  assign pullup_en = ctrl.pull;

  // R5: an external event only occurs while pin 0 is an input
  a_r5_dir_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (!pin0_is_input) |-> !ext_ev);
endmodule

// File: tb/test_port_irq_unit.sv
module test_port_irq_unit;
  localparam int DBT      = 8;
  localparam int TICK_DIV = 3;
  localparam logic [3:0] A_FLAG = 4'hD, A_EN = 4'hE, A_CTRL = 4'hF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] port_in = '0;
  logic pin0_is_input = 1'b1;
  logic sample_tick = 1'b0;
  logic [3:0] bus_addr = A_CTRL;
  logic bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic pullup_en, irq_ext, irq_port;

  int vectors = 0;
  int miscompares = 0;
  int cycles = 0;
  string phase = "R1";

  always #2 clk = ~clk;

  port_irq_unit #(.PORT_W(8), .DB_TICKS(DBT)) i_port_irq_unit (
    .clk(clk), .rst_n(rst_n), .port_in(port_in), .pin0_is_input(pin0_is_input),
    .sample_tick(sample_tick), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pullup_en(pullup_en),
    .irq_ext(irq_ext), .irq_port(irq_port)
  );

  // slow-tick strobe, changed just after each rising edge
  int tdiv = 0;
  always @(posedge clk) begin
    #1;
    tdiv = (tdiv + 1) % TICK_DIV;
    sample_tick = (tdiv == 0);
  end

  // behavioural reference model
  logic [7:0] dly [$];
  logic [7:0] m_acc, m_cand, m_prev;
  int m_run;
  bit m_fe, m_fp, m_ee, m_ep, m_pull, m_db, m_rise;

  function automatic logic [7:0] m_seen();
    return dly.size() == 2 ? dly[0] : 8'h00;
  endfunction

  initial begin
    dly = '{8'h00, 8'h00};
    m_acc = 0; m_cand = 0; m_prev = 0; m_run = 0;
    m_fe = 0; m_fp = 0; m_ee = 0; m_ep = 0; m_pull = 1; m_db = 0; m_rise = 0;
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      dly = '{8'h00, 8'h00};
      m_acc = 0; m_cand = 0; m_prev = 0; m_run = 0;
      m_fe = 0; m_fp = 0; m_ee = 0; m_ep = 0; m_pull = 1; m_db = 0; m_rise = 0;
    end else begin
      logic [7:0] seen, view;
      bit evx, evp, clx, clp;
      seen = m_seen();
      view = m_db ? m_acc : seen;
      evp = (view != m_prev);
      evx = pin0_is_input && (m_rise ? (view[0] && !m_prev[0]) : (!view[0] && m_prev[0]));
      clx = bus_wr && bus_addr == A_FLAG && bus_wdata[0];
      clp = bus_wr && bus_addr == A_FLAG && bus_wdata[1];
      m_fe = evx || (m_fe && !clx);
      m_fp = evp || (m_fp && !clp);
      // debounce window, counted in ticks
      if (!m_db) begin
        m_acc = seen; m_cand = seen; m_run = 0;
      end else if (sample_tick) begin
        if (seen == m_acc) begin m_cand = m_acc; m_run = 0; end
        else if (seen != m_cand) begin m_cand = seen; m_run = 1; end
        else if (m_run + 1 >= DBT) begin m_acc = seen; m_run = 0; end
        else m_run++;
      end
      if (bus_wr && bus_addr == A_EN) begin m_ee = bus_wdata[0]; m_ep = bus_wdata[1]; end
      if (bus_wr && bus_addr == A_CTRL) begin
        m_pull = bus_wdata[7]; m_db = bus_wdata[6]; m_rise = bus_wdata[5];
      end
      m_prev = view;
      void'(dly.pop_front());
      dly.push_back(port_in);
    end
  end

  function automatic logic [7:0] exp_rdata();
    case (bus_addr)
      A_CTRL: return {m_pull, m_db, m_rise, 5'b0};
      A_FLAG: return {6'b0, m_fp, m_fe};
      A_EN:   return {6'b0, m_ep, m_ee};
      default: return 8'h00;
    endcase
  endfunction

  task automatic check(string req, string what, logic [7:0] act, logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s (phase %s) %s: actual %h expected %h", req, phase, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    string rq;
    cycles++;
    case (bus_addr)
      A_CTRL: rq = "R2";
      A_FLAG: rq = "R9";
      default: rq = "R10";
    endcase
    check(rq, "bus_rdata", bus_rdata, exp_rdata());
    check("R2", "pullup_en", {7'b0, pullup_en}, {7'b0, m_pull});
    check("R10", "irq_ext", {7'b0, irq_ext}, {7'b0, 1'(m_fe && m_ee)});
    check("R10", "irq_port", {7'b0, irq_port}, {7'b0, 1'(m_fp && m_ep)});
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    logic [3:0] keep;
    keep = bus_addr;
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    step(1);
    bus_wr = 1'b0; bus_addr = keep;
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cycles > 20000) begin
      miscompares++;
      $display("FAIL watchdog: actual %0d cycles expected under 20000", cycles);
      finish_run();
    end
  end

  initial begin
    // R1: reset values
    phase = "R1";
    step(3);
    rst_n = 1'b1;
    step(1);
    bus_addr = A_FLAG; step(1);
    bus_addr = A_EN;   step(1);
    bus_addr = 4'h3;   step(1);
    // R2: control fields, low bits read 0
    phase = "R2";
    bus_addr = A_CTRL;
    wr(A_CTRL, 8'h3F); step(2);
    wr(A_CTRL, 8'hA0); step(2);
    // R10: enable both
    phase = "R10";
    bus_addr = A_EN;
    wr(A_EN, 8'h03); step(1);
    // R3: change upper bits, no debounce
    phase = "R3";
    bus_addr = A_FLAG;
    port_in = 8'h08; step(5);
    port_in = 8'h48; step(5);
    // R9: write 0 does nothing, write 1 clears
    phase = "R9";
    wr(A_FLAG, 8'h00); step(2);
    wr(A_FLAG, 8'h02); step(2);
    // R8: rising pin 0 with rising select sets both
    phase = "R8";
    port_in = 8'h49; step(5);
    wr(A_FLAG, 8'h03); step(2);
    // R4: polarity checks
    phase = "R4";
    port_in = 8'h48; step(5);            // falling, rise select: port only
    wr(A_FLAG, 8'h03); step(1);
    wr(A_CTRL, 8'h80); step(1);          // falling select
    port_in = 8'h49; step(5);            // rising: port only
    wr(A_FLAG, 8'h03); step(1);
    port_in = 8'h48; step(5);            // falling: both
    wr(A_FLAG, 8'h03); step(1);
    // R5: pin 0 not an input
    phase = "R5";
    pin0_is_input = 1'b0;
    port_in = 8'h49; step(5);
    port_in = 8'h48; step(5);
    wr(A_FLAG, 8'h03); step(1);
    pin0_is_input = 1'b1;
    // R10: port enable off, flag still sets
    phase = "R10";
    wr(A_EN, 8'h01); step(1);
    port_in = 8'hC8; step(5);
    bus_addr = A_EN; step(1);
    wr(A_EN, 8'h03); step(2);
    // R9: clear landing on the same edge as a new set
    phase = "R9";
    bus_addr = A_FLAG;
    port_in = 8'hC0; step(2);
    wr(A_FLAG, 8'h03); step(3);
    wr(A_FLAG, 8'h03); step(2);
    // R6: debounce on, held change
    phase = "R6";
    wr(A_CTRL, 8'hC0); step(2);
    port_in = 8'hC4; step(DBT * TICK_DIV + 12);
    wr(A_FLAG, 8'h03); step(2);
    port_in = 8'hC5; step(DBT * TICK_DIV + 12);   // pin0 rise, falling select: port only
    wr(A_FLAG, 8'h03); step(2);
    port_in = 8'hC4; step(DBT * TICK_DIV + 12);   // pin0 fall: both
    wr(A_FLAG, 8'h03); step(2);
    // R7: glitch and mid-window restart
    phase = "R7";
    port_in = 8'hC0; step(3 * TICK_DIV);
    port_in = 8'hC4; step(DBT * TICK_DIV + 12);
    port_in = 8'hD4; step(4 * TICK_DIV);
    port_in = 8'hF4; step(DBT * TICK_DIV + 12);
    wr(A_FLAG, 8'h03); step(2);
    // R3: back to bypass
    phase = "R3";
    wr(A_CTRL, 8'hA0); step(2);
    port_in = 8'hF5; step(6);
    finish_run();
  end
endmodule